// File: doc/BRIEF.md
# Cascadable Serial Dot and Control Register Port

This block is the serial loading front end of one dot-matrix LED driver. A single data input feeds one of two shift registers: a long dot register holding one bit per pixel, and an 8-bit control register. A register-select input picks which one shifts. Bits move in on rising clock edges while the active-low chip enable is held low. When chip enable goes high again, the shifted contents are copied into holding registers that the rest of the driver reads. A control load goes to one of two control words, and the top bit of the shifted word picks which one.

The serial output lets several drivers share the bus lines and form a daisy chain. Each driver's output feeds the data input of the next driver. Dot registers then join into one long chain. Control registers stay independent. In the default serial mode, loading a control word into every driver of a chain of N takes N × 8 clocks. Setting bit 0 of control word 1 selects simultaneous mode. In that mode, during control writes only, the serial output repeats the data input without a register, so every driver in the chain takes the same 8-bit word in 8 clocks.

Top module: `cascade_dot_port`

## Requirements
- R1: While `ceN` is low, each rising `clk` edge shifts `sdIn` into bit 0 of the register chosen by `regSel`: 1 selects the control shift register and 0 selects the dot shift register. Older bits move toward the higher indices. In serial mode, `sdOut` shows the top bit of the selected shift register (bit 7 for control, bit DOT_BITS-1 for dots).
- R2: On the first clock edge where `ceN` is high after being low with `regSel` high, the control shift register is copied into `ctrlWord1` if its bit 7 is 1, and into `ctrlWord0` if bit 7 is 0. The other word is left unchanged.
- R3: On the first clock edge where `ceN` is high after being low with `regSel` low, `dotWord` takes the dot shift register only when the number of dot shifts since the previous `ceN` rise is a nonzero multiple of DOT_BITS. Otherwise `dotWord` keeps its value.
- R4: When `ctrlWord1` bit 0 is 1 and `regSel` is 1, `sdOut` equals `sdIn` with no clock delay. With `regSel` at 0, `sdOut` still carries the top dot bit.
- R5: An active-low `rstN` clears both control words, the control shift register and the dot shift count. It leaves `dotWord` unchanged. All-zero control words mean serial output mode, prescaler off and sleep (bit 6 of word 0 low).
- R6: In a chain of K drivers, dot bit i of driver k is bit k·DOT_BITS+i of one K·DOT_BITS-bit register. The first bit shifted in lands at the highest position. A serial control load of K words takes K·8 clocks.
- R7: The holding registers (`dotWord`, `ctrlWord0`, `ctrlWord1`) do not change while bits are being shifted, only on a latch edge. This includes control words that select sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift and latch clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Active-low chip enable; its rise latches |
| regSel | input | 1 | 1 = control register, 0 = dot register |
| sdIn | input | 1 | Serial data input |
| sdOut | output | 1 | Serial data output to the next driver |
| dotWord | output | DOT_BITS | Latched dot pattern |
| ctrlWord0 | output | CTRL_BITS | Latched control word 0 |
| ctrlWord1 | output | CTRL_BITS | Latched control word 1 (bit 0 = output mode) |

## Verification
The bench chains three instances built with DOT_BITS = 16 and CTRL_BITS = 8. The dot chain is then 48 bits long, so many full loads fit in a short run. Those loads cover offsets that cross both driver boundaries, and incomplete loads of 10 and 17 bits. The three-driver chain also lets a single 8-bit simultaneous write be compared against a 24-clock serial write, and a later write through the chain turns simultaneous mode off again.

// File: rtl/cdp_pkg.sv
package cdp_pkg;

  // control word bit roles
  localparam int SEL_IDX   = 7;  // 1: word goes to control word 1
  localparam int MODE_IDX  = 0;  // word 1: 1 = pass-through output
  localparam int SLEEP_IDX = 6;  // word 0: 0 = sleep

  typedef struct packed {
    logic shiftDot;
    logic shiftCtrl;
    logic latchDot;
    logic latchCtrl;
  } cdpStrobe_t;

endpackage

// File: rtl/cdp_ctrl.sv
module cdp_ctrl
  import cdp_pkg::*;
#(
  parameter int DOT_BITS = 160
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       regSel,
  output cdpStrobe_t stb
);

  localparam int CNT_W = (DOT_BITS > 2) ? $clog2(DOT_BITS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DOT_BITS - 1);

  logic             ceQ;
  logic [CNT_W-1:0] dotCnt;
  logic             fullSeen;
  logic             ceRise;

  assign ceRise = ceN && !ceQ;

  always_comb begin
    stb.shiftDot  = !ceN && !regSel;
    stb.shiftCtrl = !ceN && regSel;
    stb.latchCtrl = ceRise && regSel;
    stb.latchDot  = ceRise && !regSel && fullSeen && (dotCnt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceQ      <= 1'b1;
      dotCnt   <= '0;
      fullSeen <= 1'b0;
    end else begin
      ceQ <= ceN;
      if (ceRise) begin
        dotCnt   <= '0;
        fullSeen <= 1'b0;
      end else if (stb.shiftDot) begin
        if (dotCnt == CNT_LAST) begin
          dotCnt   <= '0;
          fullSeen <= 1'b1;
        end else begin
          dotCnt <= dotCnt + 1'b1;
        end
      end
    end
  end

  // R1
  shift_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.shiftDot || stb.shiftCtrl) |-> !ceN);

  // R2
  latch_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.latchDot || stb.latchCtrl) |-> (ceN && !ceQ));

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.shiftDot, stb.shiftCtrl, stb.latchDot, stb.latchCtrl}));

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    dotCnt <= CNT_LAST);

endmodule

// File: rtl/cdp_data.sv
module cdp_data
  import cdp_pkg::*;
#(
  parameter int DOT_BITS  = 160,
  parameter int CTRL_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sdIn,
  input  logic                 regSel,
  input  cdpStrobe_t           stb,
  output logic                 sdOut,
  output logic [DOT_BITS-1:0]  dotWord,
  output logic [CTRL_BITS-1:0] ctrlWord0,
  output logic [CTRL_BITS-1:0] ctrlWord1
);

  localparam int TOP_CTRL = CTRL_BITS - 1;
  localparam int TOP_DOT  = DOT_BITS - 1;

  logic [CTRL_BITS-1:0] ctrlSr;
  logic [DOT_BITS-1:0]  dotSr;
  logic                 passMode;

  assign passMode = ctrlWord1[MODE_IDX];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlSr    <= '0;
      ctrlWord0 <= '0;
      ctrlWord1 <= '0;
    end else begin
      if (stb.shiftCtrl) ctrlSr <= {ctrlSr[TOP_CTRL-1:0], sdIn};
      if (stb.latchCtrl) begin
        if (ctrlSr[SEL_IDX]) ctrlWord1 <= ctrlSr;
        else                 ctrlWord0 <= ctrlSr;
      end
    end
  end

  // dot storage survives reset
  always_ff @(posedge clk) begin
    if (stb.shiftDot) dotSr <= {dotSr[TOP_DOT-1:0], sdIn};
    if (stb.latchDot) dotWord <= dotSr;
  end

  always_comb begin
    if (regSel) sdOut = passMode ? sdIn : ctrlSr[TOP_CTRL];
    else        sdOut = dotSr[TOP_DOT];
  end

  // R2
  ctrl_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.latchCtrl && ctrlSr[SEL_IDX]) |=> (ctrlWord1 == $past(ctrlSr)) && $stable(ctrlWord0));

  // R2
  ctrl_route0_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.latchCtrl && !ctrlSr[SEL_IDX]) |=> (ctrlWord0 == $past(ctrlSr)) && $stable(ctrlWord1));

  // R7
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.latchCtrl |=> $stable(ctrlWord0) && $stable(ctrlWord1));

endmodule

// File: rtl/cascade_dot_port.sv
module cascade_dot_port
  import cdp_pkg::*;
#(
  parameter int DOT_BITS  = 160,
  parameter int CTRL_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ceN,
  input  logic                 regSel,
  input  logic                 sdIn,
  output logic                 sdOut,
  output logic [DOT_BITS-1:0]  dotWord,
  output logic [CTRL_BITS-1:0] ctrlWord0,
  output logic [CTRL_BITS-1:0] ctrlWord1
);

  cdpStrobe_t stb;

  cdp_ctrl #(.DOT_BITS(DOT_BITS)) ctrlUnit (
    .clk    (clk),
    .rstN   (rstN),
    .ceN    (ceN),
    .regSel (regSel),
    .stb    (stb)
  );

  cdp_data #(.DOT_BITS(DOT_BITS), .CTRL_BITS(CTRL_BITS)) dataUnit (
    .clk       (clk),
    .rstN      (rstN),
    .sdIn      (sdIn),
    .regSel    (regSel),
    .stb       (stb),
    .sdOut     (sdOut),
    .dotWord   (dotWord),
    .ctrlWord0 (ctrlWord0),
    .ctrlWord1 (ctrlWord1)
  );

endmodule

// File: tb/cascade_dot_port_test.sv
module cascade_dot_port_test;

  localparam int DB  = 16;
  localparam int ND  = 3;
  localparam int TOT = DB * ND;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1;
  logic regSel = 1'b0;
  logic sdIn = 1'b0;
  logic so [ND];
  logic [DB-1:0] dw [ND];
  logic [7:0] c0 [ND];
  logic [7:0] c1 [ND];

  int checks = 0;
  int errors = 0;
  bit dotKnown = 0;

  // bench model
  logic [7:0] mSr [ND];
  logic [7:0] mC0 [ND];
  logic [7:0] mC1 [ND];
  logic [TOT-1:0] mDot;
  logic [TOT-1:0] mHold;
  int mCnt;

  always #5 clk = ~clk;

  cascade_dot_port #(.DOT_BITS(DB), .CTRL_BITS(8)) uut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .regSel(regSel), .sdIn(sdIn),
    .sdOut(so[0]), .dotWord(dw[0]), .ctrlWord0(c0[0]), .ctrlWord1(c1[0]));
  cascade_dot_port #(.DOT_BITS(DB), .CTRL_BITS(8)) uutMid (
    .clk(clk), .rstN(rstN), .ceN(ceN), .regSel(regSel), .sdIn(so[0]),
    .sdOut(so[1]), .dotWord(dw[1]), .ctrlWord0(c0[1]), .ctrlWord1(c1[1]));
  cascade_dot_port #(.DOT_BITS(DB), .CTRL_BITS(8)) uutEnd (
    .clk(clk), .rstN(rstN), .ceN(ceN), .regSel(regSel), .sdIn(so[1]),
    .sdOut(so[2]), .dotWord(dw[2]), .ctrlWord0(c0[2]), .ctrlWord1(c1[2]));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    for (int k = 0; k < ND; k++) begin
      chk(c0[k] == mC0[k], req, $sformatf("ctrlWord0[%0d]", k), 64'(c0[k]), 64'(mC0[k]));
      chk(c1[k] == mC1[k], req, $sformatf("ctrlWord1[%0d]", k), 64'(c1[k]), 64'(mC1[k]));
      if (dotKnown)
        chk(dw[k] == mHold[k*DB +: DB], req, $sformatf("dotWord[%0d]", k),
            64'(dw[k]), 64'(mHold[k*DB +: DB]));
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; ceN = 1'b1;
    for (int k = 0; k < ND; k++) begin mSr[k] = '0; mC0[k] = '0; mC1[k] = '0; end
    mCnt = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // one bit into the chain, model updated from the requirements
  task automatic shiftOne(input bit sel, input bit b, input bit chkOut);
    logic ins [ND];
    logic expOut;
    @(negedge clk);
    ceN = 1'b0; regSel = sel; sdIn = b;
    if (sel) begin
      ins[0] = b;
      for (int k = 1; k < ND; k++)
        ins[k] = mC1[k-1][0] ? ins[k-1] : mSr[k-1][7];
      expOut = mC1[0][0] ? b : mSr[0][7];
      #1;
      // R1 serial output / R4 pass-through
      if (chkOut)
        chk(so[0] === expOut, mC1[0][0] ? "R4" : "R1", "sdOut", 64'(so[0]), 64'(expOut));
      for (int k = 0; k < ND; k++) mSr[k] = {mSr[k][6:0], ins[k]};
    end else begin
      mDot = {mDot[TOT-2:0], b};
      mCnt++;
    end
  endtask

  task automatic latch();
    @(negedge clk);
    ceN = 1'b1;
    if (regSel) begin
      for (int k = 0; k < ND; k++)
        if (mSr[k][7]) mC1[k] = mSr[k]; else mC0[k] = mSr[k];
    end else if (mCnt > 0 && (mCnt % DB) == 0) begin
      mHold = mDot;
      dotKnown = 1;
    end
    mCnt = 0;
    @(negedge clk);
  endtask

  task automatic loadCtrlWord(input logic [7:0] w, input bit chkOut);
    for (int i = 7; i >= 0; i--) shiftOne(1'b1, w[i], chkOut);
  endtask

  function automatic logic [7:0] randWord();
    logic [7:0] w;
    w = 8'($urandom);
    if (w[7]) w = {1'b1, 5'b0, w[1], 1'b0};  // word 1: serial mode, reserved low
    return w;
  endfunction

  task automatic loadDots(input int n);
    for (int i = 0; i < n; i++) shiftOne(1'b0, 1'($urandom), 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] w;
    logic firstBit;
    void'($urandom(32'd1357));
    mDot = '0; mHold = '0;
    doReset();
    @(negedge clk);
    checkAll("R5");

    // R2 / R6: serial control loads, 24 clocks for three drivers
    for (int it = 0; it < 6; it++) begin
      for (int k = ND - 1; k >= 0; k--) loadCtrlWord(randWord(), 1'b1);
      latch();
      checkAll("R2_R6");
    end

    // R7: holding words stay put mid-shift
    w = randWord();
    for (int i = 7; i >= 3; i--) shiftOne(1'b1, w[i], 1'b0);
    #1;
    checkAll("R7");
    for (int i = 2; i >= 0; i--) shiftOne(1'b1, w[i], 1'b0);
    latch();
    checkAll("R2");

    // R3 / R6: full dot loads and offsets across driver boundaries
    for (int it = 0; it < 4; it++) begin
      loadDots(TOT);
      firstBit = mDot[TOT-1];
      latch();
      checkAll("R3_R6");
      chk(dw[ND-1][DB-1] == firstBit, "R6", "first bit at top of last driver",
          64'(dw[ND-1][DB-1]), 64'(firstBit));
      chk(dw[1][0] == mHold[DB], "R6", "driver 1 bit 0 at chain bit DB",
          64'(dw[1][0]), 64'(mHold[DB]));
    end

    // R3: incomplete dot loads leave the word unchanged
    loadDots(10);
    #1;
    checkAll("R7");
    latch();
    checkAll("R3");
    loadDots(DB + 1);
    latch();
    checkAll("R3");
    loadDots(DB);   // one driver's worth still counts as valid
    latch();
    checkAll("R3");

    // R4: set pass-through in every driver, then one 8-clock broadcast
    for (int k = 0; k < ND; k++) loadCtrlWord(8'h81, 1'b1);
    latch();
    checkAll("R4");
    w = 8'($urandom) & 8'h7f;
    loadCtrlWord(w, 1'b1);
    latch();
    for (int k = 0; k < ND; k++)
      chk(c0[k] == w, "R4", $sformatf("broadcast ctrlWord0[%0d]", k), 64'(c0[k]), 64'(w));
    checkAll("R4");

    // R4: dot path still shifts serially in pass-through mode
    loadDots(TOT);
    latch();
    checkAll("R4");

    // back to serial mode with one broadcast, then a serial load
    loadCtrlWord(8'h80, 1'b1);
    latch();
    checkAll("R4");
    for (int k = ND - 1; k >= 0; k--) loadCtrlWord(randWord(), 1'b1);
    latch();
    checkAll("R2_R6");

    // R5 / R7: sleep word, then reset keeps the dot pattern
    loadCtrlWord(8'h00, 1'b0);
    loadCtrlWord(8'h00, 1'b0);
    loadCtrlWord(8'h00, 1'b0);
    latch();
    checkAll("R7");
    doReset();
    @(negedge clk);
    checkAll("R5");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule